// File: doc/BRIEF.md
# External PHY Link Bring-Up Sequencer

This block brings up the link on one external Ethernet PHY and keeps watching it. It drives a small request port toward an MDIO master, which does the serial framing. On that port it issues management register reads and writes one at a time. Each request holds its address, direction and write data steady until the master returns a one-cycle done with the read data.

Once enabled, the sequencer works through these steps:
- It can reset the PHY first, then poll the control register until the reset has finished.
- It reads the PHY status register to learn which speeds and duplex modes the PHY supports.
- If the PHY can negotiate, or the configuration forces it, the sequencer advertises those abilities and starts auto-negotiation. It then polls until negotiation is complete and the link is up. After a settle interval it checks the link once more.
- If negotiation is not used, or the link is down at that check, the sequencer writes a forced speed and duplex setting instead. It then waits up to a timeout for the link to come up.

While the link is up, the status register is re-read once every settle interval. A link that drops, or a forced setup that times out, raises a one-cycle failure pulse, and the whole procedure starts again.

Top module: `phy_link_seq`

## Requirements
- R1: No request is issued while phy_present is 0 or auto_disable is 1. Either condition, arising mid-sequence, returns the sequencer to idle on the next clock, which drops req_valid and clears link_up.
- R2: With force_reset at 1, the first request writes 0x8000 to register 0. After RST_WAIT_CYC cycles, register 0 is read repeatedly until its bit 15 reads 0.
- R3: The first request after start-up, or after any reset phase, is a read of register 1. Auto-negotiation is used when bit 3 of that value is 1 or force_an is 1; otherwise the flow goes straight to the forced setup of R8.
- R4: The advertisement is written to register 4 with these fields: bit 15 = 0, bits 9:5 = status bits 15:11, bits 4:0 = 00001, and all other bits 0.
- R5: The write that follows the advertisement puts 0x1200 into register 0, which enables auto-negotiation (bit 12) and restarts it (bit 9).
- R6: Register 1 is then read again and again until a value has both bit 5 (negotiation complete) and bit 2 (link) set to 1.
- R7: After that value arrives, no request is made for SETTLE_CYC cycles. Then register 1 is read once more.
- R8: The forced setup writes register 0 with bit 13 set if any 100 Mb/s ability bit (status 15, 14 or 13) is 1. Bit 8 is set if status bit 14 is 1, or if there is no 100 Mb/s ability and status bit 12 is 1. All other bits are 0. This write happens when R3 selects no negotiation, or when the read of R7 shows bit 2 at 0.
- R9: After the forced write, register 1 is re-read repeatedly. If a read returns bit 2 at 0 once TIMEOUT_CYC cycles have passed since that write, link_fail is high for exactly one cycle and the sequence restarts with the step of R2 or R3.
- R10: link_up equals bit 2 of the most recent completed read of register 1. It is 0 after reset and after any return to idle.
- R11: While the link is up, register 1 is re-read every SETTLE_CYC cycles. A read with bit 2 at 0 raises link_fail for one cycle and restarts the sequence.
- R12: While req_valid is 1 and req_done has not arrived, req_valid stays 1 and req_addr, req_write and req_wdata stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phy_present | input | 1 | An external PHY is attached; enables the sequencer |
| auto_disable | input | 1 | Stops all automatic control |
| force_an | input | 1 | Use auto-negotiation even if the PHY does not report the ability |
| force_reset | input | 1 | Reset the PHY before the status read |
| req_valid | output | 1 | Management request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 5 | PHY register address |
| req_wdata | output | 16 | Write data |
| req_done | input | 1 | One-cycle completion from the MDIO master |
| req_rdata | input | 16 | Read data, valid with req_done |
| link_up | output | 1 | Most recent status read showed link |
| link_fail | output | 1 | One-cycle pulse when the sequence restarts after a failure |

## Verification
The PHY is modelled by a bench responder that returns scripted status and control values. Each script drives one branch of the flow:
- a PHY that negotiates;
- a PHY that has to be reset first;
- a PHY with no negotiation ability;
- a PHY with no negotiation ability but force_an set;
- a link that is lost at the re-check after negotiation;
- a link that drops while it is being monitored.

Comparing the ordered request stream with the expected one tells the negotiation path apart from the forced path. It also shows that the advertisement and forced control words follow the ability bits that were read.

The measured gaps catch a wrong settle, reset-wait or timeout count: the gap before each re-read, the gap before the first reset poll, and the time from the forced write to the failure pulse. A link_up check on every cycle catches a link flag that reflects anything other than the latest status read.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 5'd1;
  localparam logic [ADDR_W-1:0] A_ADV  = 5'd4;

  // control register bits
  localparam int CB_RESET  = 15;
  localparam int CB_SPEED  = 13;
  localparam int CB_AN_EN  = 12;
  localparam int CB_AN_RST = 9;
  localparam int CB_DUPLEX = 8;

  // status register bits
  localparam int SB_ABIL_LO = 11;
  localparam int SB_ABIL_N  = 5;
  localparam int SB_AN_DONE = 5;
  localparam int SB_AN_ABLE = 3;
  localparam int SB_LINK    = 2;

  // advertisement layout
  localparam int AB_NEXTPG  = 15;
  localparam int AB_TECH_LO = 5;
  localparam logic [4:0] SEL_IEEE = 5'b00001;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_WR, S_RST_WAIT, S_RST_POLL, S_STAT_RD,
    S_ADV_WR, S_AN_WR, S_AN_POLL, S_SETTLE, S_RECHK,
    S_MAN_WR, S_MAN_CHK, S_UP, S_MON_RD, S_FAIL
  } seq_state_e;

  function automatic logic [REG_W-1:0] adv_word(input logic [REG_W-1:0] st);
    logic [REG_W-1:0] w;
    w = '0;
    w[AB_TECH_LO +: SB_ABIL_N] = st[SB_ABIL_LO +: SB_ABIL_N];
    w[4:0] = SEL_IEEE;
    w[AB_NEXTPG] = 1'b0;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] forced_word(input logic [REG_W-1:0] st);
    logic [REG_W-1:0] w;
    logic fast;
    fast = st[15] | st[14] | st[13];
    w = '0;
    w[CB_SPEED]  = fast;
    w[CB_DUPLEX] = st[14] | (~fast & st[12]);
    return w;
  endfunction

  function automatic logic [REG_W-1:0] an_start_word();
    logic [REG_W-1:0] w;
    w = '0;
    w[CB_AN_EN]  = 1'b1;
    w[CB_AN_RST] = 1'b1;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] reset_word();
    logic [REG_W-1:0] w;
    w = '0;
    w[CB_RESET] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  assign expired = (cnt == '0);

  // R7
  expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !load |=> expired);
endmodule

// File: rtl/req_encoder.sv
module req_encoder
  import phy_seq_pkg::*;
(
  input  seq_state_e        state,
  input  logic [REG_W-1:0]  caps,
  output logic              valid,
  output logic              write,
  output logic [ADDR_W-1:0] addr,
  output logic [REG_W-1:0]  wdata
);
  always_comb begin
    valid = 1'b1;
    write = 1'b0;
    addr  = A_STAT;
    wdata = '0;
    case (state)
      S_RST_WR:   begin write = 1'b1; addr = A_CTRL; wdata = reset_word(); end
      S_RST_POLL: begin addr = A_CTRL; end
      S_STAT_RD,
      S_AN_POLL,
      S_RECHK,
      S_MAN_CHK,
      S_MON_RD:   begin addr = A_STAT; end
      S_ADV_WR:   begin write = 1'b1; addr = A_ADV; wdata = adv_word(caps); end
      S_AN_WR:    begin write = 1'b1; addr = A_CTRL; wdata = an_start_word(); end
      S_MAN_WR:   begin write = 1'b1; addr = A_CTRL; wdata = forced_word(caps); end
      default:    begin valid = 1'b0; end
    endcase
  end
endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_seq_pkg::*;
#(
  parameter int SETTLE_CYC   = 1000,
  parameter int TIMEOUT_CYC  = 100000,
  parameter int RST_WAIT_CYC = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        phy_present,
  input  logic        auto_disable,
  input  logic        force_an,
  input  logic        force_reset,
  output logic        req_valid,
  output logic        req_write,
  output logic [4:0]  req_addr,
  output logic [15:0] req_wdata,
  input  logic        req_done,
  input  logic [15:0] req_rdata,
  output logic        link_up,
  output logic        link_fail
);
  localparam int MAX_A = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int MAX_W = (MAX_A > RST_WAIT_CYC) ? MAX_A : RST_WAIT_CYC;
  localparam int TMR_W = $clog2(MAX_W + 1);

  seq_state_e        state, nxt;
  logic [REG_W-1:0]  caps;
  logic              tmr_load, tmr_expired;
  logic [TMR_W-1:0]  tmr_val;

  // named internal events
  logic abort, xfer_done, stat_rd_done, rd_link, rd_an_ok, rst_clear;
  assign abort        = ~phy_present | auto_disable;
  assign xfer_done    = req_valid & req_done;
  assign stat_rd_done = xfer_done & ~req_write & (req_addr == A_STAT);
  assign rd_link      = req_rdata[SB_LINK];
  assign rd_an_ok     = req_rdata[SB_AN_DONE] & req_rdata[SB_LINK];
  assign rst_clear    = ~req_rdata[CB_RESET];

  req_encoder u_enc (
    .state (state),
    .caps  (caps),
    .valid (req_valid),
    .write (req_write),
    .addr  (req_addr),
    .wdata (req_wdata)
  );

  seq_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (abort) begin
      nxt = S_IDLE;
    end else begin
      case (state)
        S_IDLE:     nxt = force_reset ? S_RST_WR : S_STAT_RD;
        S_RST_WR:   if (xfer_done) begin
                      nxt = S_RST_WAIT; tmr_load = 1'b1; tmr_val = TMR_W'(RST_WAIT_CYC);
                    end
        S_RST_WAIT: if (tmr_expired) nxt = S_RST_POLL;
        S_RST_POLL: if (xfer_done && rst_clear) nxt = S_STAT_RD;
        S_STAT_RD:  if (xfer_done)
                      nxt = (req_rdata[SB_AN_ABLE] | force_an) ? S_ADV_WR : S_MAN_WR;
        S_ADV_WR:   if (xfer_done) nxt = S_AN_WR;
        S_AN_WR:    if (xfer_done) nxt = S_AN_POLL;
        S_AN_POLL:  if (xfer_done && rd_an_ok) begin
                      nxt = S_SETTLE; tmr_load = 1'b1; tmr_val = TMR_W'(SETTLE_CYC);
                    end
        S_SETTLE:   if (tmr_expired) nxt = S_RECHK;
        S_RECHK:    if (xfer_done) begin
                      if (rd_link) begin
                        nxt = S_UP; tmr_load = 1'b1; tmr_val = TMR_W'(SETTLE_CYC);
                      end else begin
                        nxt = S_MAN_WR;
                      end
                    end
        S_MAN_WR:   if (xfer_done) begin
                      nxt = S_MAN_CHK; tmr_load = 1'b1; tmr_val = TMR_W'(TIMEOUT_CYC);
                    end
        S_MAN_CHK:  if (xfer_done) begin
                      if (rd_link) begin
                        nxt = S_UP; tmr_load = 1'b1; tmr_val = TMR_W'(SETTLE_CYC);
                      end else if (tmr_expired) begin
                        nxt = S_FAIL;
                      end
                    end
        S_UP:       if (tmr_expired) nxt = S_MON_RD;
        S_MON_RD:   if (xfer_done) begin
                      if (rd_link) begin
                        nxt = S_UP; tmr_load = 1'b1; tmr_val = TMR_W'(SETTLE_CYC);
                      end else begin
                        nxt = S_FAIL;
                      end
                    end
        S_FAIL:     nxt = S_IDLE;
        default:    nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      caps    <= '0;
      link_up <= 1'b0;
    end else begin
      state <= nxt;
      if (!abort && state == S_STAT_RD && xfer_done) caps <= req_rdata;
      if (abort || state == S_FAIL) link_up <= 1'b0;
      else if (stat_rd_done)        link_up <= rd_link;
    end
  end

  assign link_fail = (state == S_FAIL);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_done && !abort |=>
      req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata));

  // R1
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !req_valid && !link_up);

  // R10
  link_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_done && !abort && state != S_FAIL |=> link_up == $past(rd_link));

  // R9
  fail_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |=> !link_fail && !link_up);

  // R7
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_AN_POLL && xfer_done && rd_an_ok && !abort |=> !req_valid);
endmodule

// File: tb/phy_link_seq_test.sv
module phy_link_seq_test;
  localparam int CLK_P = 20;
  localparam int LAT   = 3;
  localparam int SET   = 8;
  localparam int TMO   = 40;
  localparam int RSTW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic phy_present = 1'b0, auto_disable = 1'b1, force_an = 1'b0, force_reset = 1'b0;
  logic req_valid, req_write;
  logic [4:0] req_addr;
  logic [15:0] req_wdata;
  logic req_done = 1'b0;
  logic [15:0] req_rdata = '0;
  logic link_up, link_fail;

  phy_link_seq #(.SETTLE_CYC(SET), .TIMEOUT_CYC(TMO), .RST_WAIT_CYC(RSTW)) uut (
    .clk(clk), .rst_n(rst_n), .phy_present(phy_present), .auto_disable(auto_disable),
    .force_an(force_an), .force_reset(force_reset), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_done(req_done), .req_rdata(req_rdata), .link_up(link_up), .link_fail(link_fail));

  int errors = 0, checks = 0, cyc = 0;
  logic [15:0] st_q[$], ctl_q[$];
  logic [15:0] st_def = '0, ctl_def = '0;
  logic [22:0] exp_q[$];          // {repeat, write, addr, data}
  int tag_q[$];
  bit exp_link = 0, pend_clear = 0, p_valid = 0, up_seen = 0;
  int lat_cnt = 0, fail_cnt = 0, fail_cyc = -1, man_done_cyc = -1;
  int ctl_rd_cnt = 0, valid_cnt = 0, last_done_cyc = 0;
  logic s_w = 0, p_w = 0;
  logic [4:0] s_a = '0, p_a = '0;
  logic [15:0] s_d = '0, p_d = '0, rd = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit tmatch(input logic [22:0] e, input logic w, input logic [4:0] a,
                                input logic [15:0] d);
    return (e[21] == w) && (e[20:16] == a) && (!w || e[15:0] == d);
  endfunction

  task automatic ex(input bit rep, input logic w, input logic [4:0] a, input logic [15:0] d,
                    input int tag);
    exp_q.push_back({rep, w, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic compare_xfer(input logic w, input logic [4:0] a, input logic [15:0] d);
    checks++;
    while (exp_q.size() > 1 && exp_q[0][22] && !tmatch(exp_q[0], w, a, d)) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R3 unexpected request actual w=%0b a=%0d d=%h expected none", w, a, d);
    end else if (tmatch(exp_q[0], w, a, d)) begin
      if (!exp_q[0][22]) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end else begin
      errors++;
      $display("FAIL R%0d request actual w=%0b a=%0d d=%h expected w=%0b a=%0d d=%h",
               tag_q[0], w, a, d, exp_q[0][21], exp_q[0][20:16], exp_q[0][15:0]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  endtask

  // cycle-by-cycle PHY/MDIO responder and link reference
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      checks++;
      if (link_up !== exp_link) begin
        errors++;
        $display("FAIL R10 link_up actual=%0b expected=%0b cycle %0d", link_up, exp_link, cyc);
      end
      if (link_up) up_seen = 1;
      if (req_valid) valid_cnt++;
      if (link_fail) begin
        fail_cnt++;
        if (fail_cyc < 0) fail_cyc = cyc;
      end
    end
    if (pend_clear) begin exp_link = 0; pend_clear = 0; end
    if (req_done) begin
      req_done = 1'b0;
      lat_cnt = 0;
    end else if (rst_n && req_valid && phy_present && !auto_disable) begin
      if (lat_cnt == 0) begin
        s_w = req_write; s_a = req_addr; s_d = req_wdata;
        if (p_valid && !req_write && req_addr == 5'd1 && !p_w && p_a == 5'd1 && p_d[5] && p_d[2])
          chk((cyc - last_done_cyc) >= SET && (cyc - last_done_cyc) <= SET + 3,
              "R7 settle gap", cyc - last_done_cyc, SET + 2);
        if (p_valid && !req_write && req_addr == 5'd0 && p_w && p_a == 5'd0 && p_d == 16'h8000)
          chk((cyc - last_done_cyc) >= RSTW && (cyc - last_done_cyc) <= RSTW + 3,
              "R2 reset wait gap", cyc - last_done_cyc, RSTW + 2);
      end else begin
        chk({req_write, req_addr, req_wdata} === {s_w, s_a, s_d}, "R12 request hold",
            int'(req_wdata), int'(s_d));
      end
      lat_cnt++;
      if (lat_cnt == LAT) begin
        if (s_w) begin
          rd = s_d;
          if (s_a == 5'd0 && s_d == 16'h2100) man_done_cyc = cyc;
        end else if (s_a == 5'd1) begin
          rd = (st_q.size() > 0) ? st_q.pop_front() : st_def;
          exp_link = rd[2];
        end else begin
          rd = (ctl_q.size() > 0) ? ctl_q.pop_front() : ctl_def;
          ctl_rd_cnt++;
        end
        req_rdata = rd;
        req_done = 1'b1;
        compare_xfer(s_w, s_a, s_w ? s_d : 16'h0);
        p_valid = 1; p_w = s_w; p_a = s_a; p_d = rd; last_done_cyc = cyc;
      end
    end else begin
      lat_cnt = 0;
    end
  end

  task automatic cfg(input logic p, input logic d, input logic fa, input logic fr);
    @(posedge clk); #2;
    phy_present = p; auto_disable = d; force_an = fa; force_reset = fr;
    if (!p || d) pend_clear = 1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic prep();
    cfg(1'b0, 1'b1, 1'b0, 1'b0);
    wait_cyc(6);
    st_q.delete(); ctl_q.delete(); exp_q.delete(); tag_q.delete();
    fail_cnt = 0; fail_cyc = -1; man_done_cyc = -1; ctl_rd_cnt = 0;
    valid_cnt = 0; up_seen = 0; p_valid = 0;
  endtask

  task automatic drained(input string req);
    int left = 0;
    foreach (exp_q[i]) if (!exp_q[i][22]) left++;
    chk(left == 0, req, left, 0);
  endtask

  bit finished = 0;
  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    // R1 reset state
    #2;
    chk(req_valid == 1'b0, "R1 reset req_valid", req_valid, 0);
    chk(link_up == 1'b0 && link_fail == 1'b0, "R10 reset link flags", link_up, 0);
    rst_n = 1'b1;

    // R1: absent PHY, then disabled selection
    prep();
    cfg(1'b0, 1'b0, 1'b0, 1'b0);
    wait_cyc(40);
    cfg(1'b1, 1'b1, 1'b1, 1'b1);
    wait_cyc(40);
    chk(valid_cnt == 0, "R1 no request while idle", valid_cnt, 0);

    // negotiating PHY, monitored link then dropped (R3 R4 R5 R6 R7 R11)
    prep();
    st_q = '{16'h7808, 16'h7808, 16'h782C, 16'h782C, 16'h782C, 16'h7808};
    st_def = 16'h7808;
    ex(0, 0, 5'd1, 16'h0, 3);
    ex(0, 1, 5'd4, 16'h01E1, 4);
    ex(0, 1, 5'd0, 16'h1200, 5);
    ex(1, 0, 5'd1, 16'h0, 6);
    ex(0, 1, 5'd4, 16'h01E1, 4);   // after restart (R11)
    ex(0, 1, 5'd0, 16'h1200, 5);
    ex(1, 0, 5'd1, 16'h0, 6);
    cfg(1'b1, 1'b0, 1'b0, 1'b0);
    wait_cyc(200);
    chk(up_seen, "R6 link reached", up_seen, 1);
    chk(fail_cnt == 1, "R11 fail pulse count", fail_cnt, 1);
    drained("R11 request stream complete");

    // force reset path (R2)
    prep();
    ctl_q = '{16'h8000, 16'h8000};
    ctl_def = 16'h1000;
    st_q = '{16'h7808, 16'h782C, 16'h782C};
    st_def = 16'h782C;
    ex(0, 1, 5'd0, 16'h8000, 2);
    ex(1, 0, 5'd0, 16'h0, 2);
    ex(0, 0, 5'd1, 16'h0, 3);
    ex(0, 1, 5'd4, 16'h01E1, 4);
    ex(0, 1, 5'd0, 16'h1200, 5);
    ex(1, 0, 5'd1, 16'h0, 6);
    cfg(1'b1, 1'b0, 1'b0, 1'b1);
    wait_cyc(150);
    chk(ctl_rd_cnt == 3, "R2 control polls", ctl_rd_cnt, 3);
    chk(link_up == 1'b1, "R6 link after reset path", link_up, 1);
    drained("R2 request stream complete");
    cfg(1'b1, 1'b1, 1'b0, 1'b1);
    wait_cyc(2); #2;
    chk(req_valid == 1'b0 && link_up == 1'b0, "R1 abort clears", link_up, 0);

    // no negotiation ability: forced setup (R8)
    prep();
    st_q = '{16'h6000, 16'h6000, 16'h6000};
    st_def = 16'h6004;
    ex(0, 0, 5'd1, 16'h0, 3);
    ex(0, 1, 5'd0, 16'h2100, 8);
    ex(1, 0, 5'd1, 16'h0, 9);
    cfg(1'b1, 1'b0, 1'b0, 1'b0);
    wait_cyc(150);
    chk(link_up == 1'b1, "R8 forced link up", link_up, 1);
    chk(fail_cnt == 0, "R9 no failure", fail_cnt, 0);
    drained("R8 request stream complete");

    // force_an overrides missing ability (R3 R4)
    prep();
    st_q = '{16'h1000};
    st_def = 16'h102C;
    ex(0, 0, 5'd1, 16'h0, 3);
    ex(0, 1, 5'd4, 16'h0041, 4);
    ex(0, 1, 5'd0, 16'h1200, 5);
    ex(1, 0, 5'd1, 16'h0, 6);
    cfg(1'b1, 1'b0, 1'b1, 1'b0);
    wait_cyc(100);
    chk(link_up == 1'b1, "R3 forced negotiation link", link_up, 1);
    drained("R4 request stream complete");

    // re-check down -> forced -> timeout -> restart (R8 R9)
    prep();
    st_q = '{16'h7808, 16'h782C, 16'h7808};
    st_def = 16'h7808;
    ex(0, 0, 5'd1, 16'h0, 3);
    ex(0, 1, 5'd4, 16'h01E1, 4);
    ex(0, 1, 5'd0, 16'h1200, 5);
    ex(1, 0, 5'd1, 16'h0, 7);
    ex(0, 1, 5'd0, 16'h2100, 8);
    ex(1, 0, 5'd1, 16'h0, 9);
    ex(0, 1, 5'd4, 16'h01E1, 9);
    ex(0, 1, 5'd0, 16'h1200, 9);
    ex(1, 0, 5'd1, 16'h0, 6);
    cfg(1'b1, 1'b0, 1'b0, 1'b0);
    wait_cyc(200);
    chk(fail_cnt == 1, "R9 fail pulse count", fail_cnt, 1);
    chk(man_done_cyc > 0 && (fail_cyc - man_done_cyc) >= TMO &&
        (fail_cyc - man_done_cyc) <= TMO + LAT + 4, "R9 timeout window",
        fail_cyc - man_done_cyc, TMO + LAT + 2);
    drained("R9 request stream complete");

    prep();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule